// File: doc/BRIEF.md
# Dual-Address SMBus Target with Byte Memory and Command Registers

This block is a synchronous I2C/SMBus target that sits on a management bus and answers on two addresses. Both addresses come from one set of three strap inputs. One address opens a 256-byte user memory, which is accessed one byte per transfer. The other opens a small bank of 16-bit command registers, which can be written and read as bytes or as words. Decoding what each command register means is left to the logic around the block.

SCL and SDA are synchronised into the system clock and then sampled. The block pulls SDA low through an open-drain enable and never holds SCL. START and STOP conditions are honoured at any bit position. After a memory write completes, the memory address is refused for a fixed window while the stored byte is treated as being programmed. If SCL stays low too long, the interface lets go of SDA and waits for the next START. A write-protect input makes memory writes silent: they are still acknowledged, but nothing is stored.

Top module: `smbus_dual_target`

## Requirements
- R1: The target acknowledges an 8-bit address byte (7-bit address followed by the R/W bit) of 0xB0 + 2*strap for the command bank, and of 0xA0 + 2*strap for the memory. Here strap is the 3-bit strap value, so it lands in address bits 3..1. The ACK is SDA driven low during the ninth clock.
- R2: An address byte that matches neither address is not acknowledged. The target then drives SDA for nothing until the next START, including bytes that would otherwise match.
- R3: A memory write is START, memory address with R/W=0, one data-address byte, one data byte, STOP. The target acknowledges each of these bytes and NACKs any further data byte in the same frame.
- R4: A memory read is a write of the data address, then a repeated START with the memory address and R/W=1. The target returns the byte stored at that data address.
- R5: While wp is high, a memory data byte is acknowledged but the stored contents stay unchanged.
- R6: A STOP that ends a frame containing an acknowledged memory data byte opens a busy window of BUSY_CYCLES clocks. During this window the memory address is NACKed. The command address is served as usual.
- R7: A START or STOP seen while SCL is high ends the frame in progress at any bit position. After a START, a new address byte is expected.
- R8: If SCL stays low for TIMEOUT_CYCLES clocks, the target releases SDA and ignores the bus until the next START.
- R9: In a command write, the first byte after the address selects register (byte mod CMD_WORDS). The frame may then end, or carry one data byte (the low byte of the register) or two data bytes (low byte, then high byte). A third data byte is NACKed.
- R10: A command read after a repeated START returns the low byte of the selected register first, then the high byte. Any byte read after those two is 0xFF.
- R11: After reset, SDA is released and every command register reads 0x0000.
- R12: The target changes SDA from released to driven only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level, asynchronous |
| strap | input | 3 | Address straps A2..A0; an open pin is pulled to 1 on the board |
| wp | input | 1 | Memory write-protect, active high |
| sda_oe | output | 1 | Pulls SDA low when 1, releases it when 0 |

## Verification
The bench keeps the memory at its full 256 bytes and the command bank at eight words. It shortens BUSY_CYCLES to 400 and TIMEOUT_CYCLES to 3000. With a 400 busy window, a memory address sent immediately after a write STOP falls inside the window, and a retry after a short wait falls outside it. With a 3000 timeout, SCL can be held low past the limit while the target is driving a read bit of 0. Both checks fit in a run a few thousand clocks long.

// File: rtl/smbus_tgt_pkg.sv
package smbus_tgt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_t;

  localparam logic [3:0] CMD_PREFIX = 4'b1011;
  localparam logic [3:0] MEM_PREFIX = 4'b1010;

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign cur[g]  = chain[STAGES-1];
    assign prev[g] = last;
  end

endmodule

// File: rtl/smbus_span_timer.sv
module smbus_span_timer #(
  parameter int LIMIT      = 1000,
  parameter bit START_DONE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= START_DONE ? LIM : '0;
    else if (clear)       cnt <= '0;
    else if (cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

endmodule

// File: rtl/smbus_byte_mem.sv
module smbus_byte_mem #(
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/smbus_cmd_bank.sv
module smbus_cmd_bank #(
  parameter int WORDS = 16,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  input  logic [1:0]    sel,
  output logic [7:0]    rdata
);

  logic [15:0] regs [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) regs[i] <= '0;
    end else begin
      if (we_lo) regs[idx][7:0]  <= wdata;
      if (we_hi) regs[idx][15:8] <= wdata;
    end
  end

  always_comb begin
    case (sel)
      2'd0:    rdata = regs[idx][7:0];
      2'd1:    rdata = regs[idx][15:8];
      default: rdata = 8'hFF;
    endcase
  end

endmodule

// File: rtl/smbus_dual_target.sv
module smbus_dual_target
  import smbus_tgt_pkg::*;
#(
  parameter int MEM_DEPTH      = 256,
  parameter int CMD_WORDS      = 16,
  parameter int BUSY_CYCLES    = 50_000,
  parameter int TIMEOUT_CYCLES = 1_250_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe
);

  localparam int MAW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam int CAW = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;

  // line sampling and bus events
  logic [1:0] ln_cur, ln_prev;
  smbus_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw({sda_i, scl_i}), .cur(ln_cur), .prev(ln_prev)
  );

  logic scl_s, sda_s, scl_q, sda_q;
  assign scl_s = ln_cur[0];
  assign sda_s = ln_cur[1];
  assign scl_q = ln_prev[0];
  assign sda_q = ln_prev[1];

  logic start_evt, stop_evt, scl_rise, scl_fall;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  // frame state
  phase_t         phase;
  logic [3:0]     bitcnt;
  logic [7:0]     shreg;
  logic           rw, to_mem, nack_slot, m_nack, wrote_mem;
  logic [1:0]     widx, ridx;
  logic [MAW-1:0] mptr;
  logic [CAW-1:0] cptr;

  // timers
  logic busy_done, mem_busy, tmo_done;
  smbus_span_timer #(.LIMIT(BUSY_CYCLES), .START_DONE(1'b1)) u_busy (
    .clk(clk), .rst(rst), .clear(stop_evt & wrote_mem), .done(busy_done)
  );
  assign mem_busy = ~busy_done;

  smbus_span_timer #(.LIMIT(TIMEOUT_CYCLES), .START_DONE(1'b0)) u_tmo (
    .clk(clk), .rst(rst), .clear(scl_s), .done(tmo_done)
  );

  // decode
  logic hit_cmd, hit_mem, byte_end, wr_ack;
  assign hit_cmd  = (shreg[7:1] == {CMD_PREFIX, strap});
  assign hit_mem  = (shreg[7:1] == {MEM_PREFIX, strap}) && !mem_busy;
  assign byte_end = scl_fall && (bitcnt == 4'd8) && (phase == PH_WRITE);
  assign wr_ack   = (widx == 2'd0) || (widx == 2'd1) || (widx == 2'd2 && !to_mem);

  logic mem_we, cmd_we_lo, cmd_we_hi;
  assign mem_we    = byte_end && to_mem && (widx == 2'd1) && !wp;
  assign cmd_we_lo = byte_end && !to_mem && (widx == 2'd1);
  assign cmd_we_hi = byte_end && !to_mem && (widx == 2'd2);

  // storage
  logic [7:0] mem_q, cmd_q, rd_byte;
  smbus_byte_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mptr), .wdata(shreg),
    .raddr(mptr), .rdata(mem_q)
  );

  smbus_cmd_bank #(.WORDS(CMD_WORDS)) u_cmd (
    .clk(clk), .rst(rst), .we_lo(cmd_we_lo), .we_hi(cmd_we_hi),
    .idx(cptr), .wdata(shreg), .sel(ridx), .rdata(cmd_q)
  );

  assign rd_byte = to_mem ? mem_q : cmd_q;

  // bit engine
  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      rw        <= 1'b0;
      to_mem    <= 1'b0;
      nack_slot <= 1'b0;
      m_nack    <= 1'b0;
      wrote_mem <= 1'b0;
      widx      <= '0;
      ridx      <= '0;
      mptr      <= '0;
      cptr      <= '0;
      sda_oe    <= 1'b0;
    end else if (start_evt) begin
      phase  <= PH_ADDR;
      bitcnt <= '0;
      widx   <= '0;
      ridx   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      phase     <= PH_IDLE;
      wrote_mem <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (tmo_done) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else if (phase != PH_IDLE && phase != PH_SKIP) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          if (phase != PH_READ) shreg <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else if (bitcnt == 4'd8) begin
          if (phase == PH_READ) m_nack <= sda_s;
          bitcnt <= 4'd9;
        end
      end
      if (scl_fall) begin
        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
          if (phase == PH_READ) begin
            sda_oe <= ~shreg[7];
            shreg  <= {shreg[6:0], 1'b0};
          end
        end else if (bitcnt == 4'd8) begin
          case (phase)
            PH_ADDR: begin
              sda_oe    <= hit_cmd | hit_mem;
              nack_slot <= ~(hit_cmd | hit_mem);
              to_mem    <= hit_mem;
              rw        <= shreg[0];
            end
            PH_WRITE: begin
              sda_oe    <= wr_ack;
              nack_slot <= ~wr_ack;
              if (widx == 2'd0) begin
                if (to_mem) mptr <= shreg[MAW-1:0];
                else        cptr <= shreg[CAW-1:0];
              end
              if (widx == 2'd1 && to_mem) wrote_mem <= 1'b1;
              if (widx != 2'd3) widx <= widx + 1'b1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          if ((phase == PH_ADDR && !nack_slot && rw) ||
              (phase == PH_READ && !m_nack)) begin
            phase  <= PH_READ;
            sda_oe <= ~rd_byte[7];
            shreg  <= {rd_byte[6:0], 1'b0};
            if (ridx != 2'd2) ridx <= ridx + 1'b1;
          end else if (phase == PH_ADDR && !nack_slot) begin
            phase <= PH_WRITE;
          end else if (nack_slot || phase == PH_READ) begin
            phase <= PH_SKIP;
          end
        end
      end
    end
  end

endmodule

// File: rtl/smbus_dual_target_chk.sv
module smbus_dual_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic sda_oe,
  input logic start_evt,
  input logic stop_evt,
  input logic tmo_done,
  input logic wrote_mem,
  input logic mem_busy
);

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !sda_oe); // R7
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe); // R7
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    tmo_done |=> !sda_oe); // R8
  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && wrote_mem) |=> mem_busy); // R6
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s)); // R12

endmodule

bind smbus_dual_target smbus_dual_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .tmo_done(tmo_done),
  .wrote_mem(wrote_mem), .mem_busy(mem_busy)
);

// File: tb/tb_smbus_dual_target.sv
module tb_smbus_dual_target;

  localparam int Q    = 8;
  localparam int BUSY = 400;
  localparam int TMO  = 3000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       wp = 1'b0;
  logic [2:0] strap = 3'd0;
  logic       sda_oe;
  logic       sda_line;
  int n_run = 0, n_fail = 0, drive_hi_viol = 0;
  bit done = 1'b0;

  assign sda_line = ~(m_low | sda_oe);

  always #10 clk = ~clk;

  smbus_dual_target #(
    .MEM_DEPTH(256), .CMD_WORDS(8), .BUSY_CYCLES(BUSY), .TIMEOUT_CYCLES(TMO)
  ) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .strap(strap), .wp(wp), .sda_oe(sda_oe)
  );

  // R12 monitor: target must not start pulling SDA while SCL is high
  logic oe_d = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_oe && !oe_d && scl) drive_hi_viol++;
    oe_d <= sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bstart();
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bstop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q);
      scl = 1'b1;    tick(2*Q);
      scl = 1'b0;    tick(Q);
    end
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = ~sda_line; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic rbyte(input bit last, output logic [7:0] d);
    m_low = 1'b0;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      d = {d[6:0], sda_line}; tick(Q);
      scl = 1'b0; tick(Q);
    end
    m_low = ~last; tick(Q);
    scl = 1'b1;    tick(2*Q);
    scl = 1'b0;    tick(Q);
    m_low = 1'b0;
  endtask

  // set register/data pointer, then repeated START into read
  task automatic point_read(input logic [7:0] dev, input logic [7:0] ptr, output bit ok);
    bit a0, a1, a2;
    bstart(); wbyte(dev, a0); wbyte(ptr, a1);
    bstart(); wbyte(dev | 8'h01, a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic t_reset();
    logic [7:0] lo, hi; bit ok;
    check("R11 SDA released after reset", sda_line, 1);
    point_read(8'hB0, 8'h05, ok);
    rbyte(1'b0, lo); rbyte(1'b1, hi); bstop();
    check("R11 read path acked", ok, 1);
    check("R11 cmd reg cleared", {hi, lo}, 16'h0000);
  endtask

  task automatic t_mem_rw();
    bit a; logic [7:0] d; bit ok;
    bstart(); wbyte(8'hA0, a); check("R1 memory address ack", a, 1);
    wbyte(8'h12, a); check("R3 data address ack", a, 1);
    wbyte(8'h5A, a); check("R3 data byte ack", a, 1);
    wbyte(8'h66, a); check("R3 extra data byte nack", a, 0);
    bstop();
    bstart(); wbyte(8'hA0, a); check("R6 memory nack while busy", a, 0); bstop();
    bstart(); wbyte(8'hB0, a); check("R6 command served while busy", a, 1); bstop();
    tick(BUSY + 50);
    point_read(8'hA0, 8'h12, ok); rbyte(1'b1, d); bstop();
    check("R6 memory served after window", ok, 1);
    check("R4 memory read returns byte", d, 8'h5A);
  endtask

  task automatic t_wp();
    bit a; logic [7:0] d; bit ok;
    wp = 1'b1;
    bstart(); wbyte(8'hA0, a); wbyte(8'h12, a); wbyte(8'hFF, a); bstop();
    check("R5 protected write acked", a, 1);
    wp = 1'b0;
    tick(BUSY + 50);
    point_read(8'hA0, 8'h12, ok); rbyte(1'b1, d); bstop();
    check("R5 protected byte unchanged", d, 8'h5A);
  endtask

  task automatic t_cmd();
    bit a, a3; logic [7:0] b0, b1, b2; bit ok;
    bstart(); wbyte(8'hB0, a); wbyte(8'h03, a); wbyte(8'h34, a); wbyte(8'h12, a);
    wbyte(8'h99, a3); bstop();
    check("R9 high byte acked", a, 1);
    check("R9 third data byte nack", a3, 0);
    point_read(8'hB0, 8'h03, ok);
    rbyte(1'b0, b0); rbyte(1'b0, b1); rbyte(1'b1, b2); bstop();
    check("R10 word read low/high", {b1, b0}, 16'h1234);
    check("R10 byte past word is FF", b2, 8'hFF);
    bstart(); wbyte(8'hB0, a); wbyte(8'h0B, a); wbyte(8'h77, a); bstop();
    bstart(); wbyte(8'hB0, a); wbyte(8'h03, a); bstop();
    point_read(8'hB0, 8'h03, ok); rbyte(1'b0, b0); rbyte(1'b1, b1); bstop();
    check("R9 byte write to index mod size", {b1, b0}, 16'h1277);
  endtask

  task automatic t_mismatch();
    bit a;
    bstart(); wbyte(8'hC0, a); check("R2 foreign address nack", a, 0);
    wbyte(8'hB0, a); check("R2 silent until START", a, 0);
    wbyte(8'hA0, a); check("R2 still silent", a, 0);
    bstop();
  endtask

  task automatic t_strap();
    bit a;
    strap = 3'd5;
    bstart(); wbyte(8'hB0, a); check("R1 old command address nack", a, 0); bstop();
    bstart(); wbyte(8'hBA, a); check("R1 strapped command address ack", a, 1); bstop();
    bstart(); wbyte(8'hAA, a); check("R1 strapped memory address ack", a, 1); bstop();
    strap = 3'd0;
  endtask

  task automatic t_restart();
    bit a; logic [7:0] d; bit ok;
    bstart(); wbyte(8'hB0, a);
    for (int i = 0; i < 3; i++) begin
      m_low = 1'b1; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    point_read(8'hB0, 8'h03, ok); rbyte(1'b1, d); bstop();
    check("R7 START mid-byte restarts frame", ok, 1);
    check("R7 read after restart", d, 8'h77);
    bstart(); wbyte(8'hB0, a);
    for (int i = 0; i < 2; i++) begin
      m_low = 1'b0; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    bstop();
    bstart(); wbyte(8'hB0, a); bstop();
    check("R7 STOP mid-byte then new frame", a, 1);
  endtask

  task automatic t_timeout();
    bit ok; logic [7:0] d;
    point_read(8'hB0, 8'h03, ok);
    tick(10);
    check("R8 target driving read bit", sda_line, 0);
    tick(TMO - 300);
    check("R8 still driving before limit", sda_line, 0);
    tick(400);
    check("R8 SDA released after timeout", sda_line, 1);
    bstop();
    point_read(8'hB0, 8'h03, ok); rbyte(1'b1, d); bstop();
    check("R8 bus usable after recovery", d, 8'h77);
  endtask

  initial begin
    tick(5); rst = 1'b0; tick(5);
    t_reset();
    t_mem_rw();
    t_wp();
    t_cmd();
    t_mismatch();
    t_strap();
    t_restart();
    t_timeout();
    check("R12 no SDA drive start while SCL high", drive_hi_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule